// File: doc/BRIEF.md
# Raster Line Counter with Sync Status

This block keeps the raster position of a display whose size, sync widths and scan mode are set by register writes. A dot counter advances once per dot clock and wraps at the end of each line. On each wrap a line counter advances, and that counter wraps at the end of the frame. In interlaced mode a field flag flips at every frame wrap. A one-cycle frame-end strobe and a frame counter mark each time the raster enters a fixed line near the top of the frame.

Every cycle, a 14-bit status word is derived combinationally from the position. It packs the current line, the field flag and three flags: display active, horizontal sync released and vertical sync released. When the current line's parity equals the field flag, the flags follow the start-of-line rules (sync width, then front porch). When the parities differ, they follow end-of-line rules (a back porch of fixed length). This models the half-line offset between the two interleaved fields.

Top module: `raster_timing`

## Requirements
- R1: While reset is held, the line and dot counters, the field flag, the frame-end strobe, the frame counter and the status word are all zero. Reset values are 864 dots × 625 lines, sync width word 0x07D6A53F, progressive mode and front-porch field 0.
- R2: The dot counter runs from 0 to the dots field (bits 9:0 of the size word) and then returns to 0. On that return the line counter advances.
- R3: The line counter returns to 0 after the value in size-word bits 25:16. At that return the field flag inverts when configuration bit 4 is 1, and it is unchanged when that bit is 0.
- R4: When the line counter advances into line 42 (0x2A), frame_end is high for exactly one cycle, with dot count 0, and the frame counter increments by one. The strobes are one frame apart.
- R5: Status bits 9:0 equal the line count and status bit 10 equals the field flag.
- R6: When the line parity equals the field flag, status bit 12 is set once the dot count exceeds 2 × (sync word bits 6:0 + 1).
- R7: When the line parity equals the field flag and the line is at or beyond the vsync count (sync word bits 11:8), bit 13 is set. Bit 11 is also set once the dot count exceeds front-porch bits 9:0 + 1. On earlier lines both bits are clear.
- R8: When the line parity differs from the field flag and the line is at or beyond the vsync count, bits 12 and 13 are set. Bit 11 is set only while dot + BACK_PORCH is below the dots per line.
- R9: When the line parity differs from the field flag and the line is below the vsync count, only bit 12 of the flag bits is set.
- R10: A write of the size word (masked with 0x03FF03FF) returns the dot counter to 0. It keeps the line count, lowered to the new last line if it was beyond that line.
- R11: Write select codes: 0 is the size word, 1 is the sync width word, 2 is the configuration word, 3 is the front-porch word. A write takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| line_cnt | output | 10 | Current line |
| dot_cnt | output | 10 | Current dot within the line |
| field_odd | output | 1 | Field flag, 1 for the odd field |
| frame_end | output | 1 | One-cycle strobe on entering line 42 |
| frame_count | output | FRAME_W | Frames seen since reset |
| status | output | 14 | Sync status word |

## Verification
The hardest states to reach are the mismatched-parity cases in the odd field. They occur only after a whole frame has wrapped with interlace enabled. The bench shrinks the raster to 20 × 50 and waits on the port-visible position (field, line, dot) for each table entry, so each status rule is sampled at the exact dot on either side of its threshold. The clamping write is issued while the raster sits deep in the frame, and the result is observed on the very next cycle.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int FRAME_W = 16,
  parameter int BACK_PORCH = 54,
  parameter logic [9:0] FRAME_LINE = 10'h2A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output logic [9:0]         line_cnt,
  output logic [9:0]         dot_cnt,
  output logic               field_odd,
  output logic               frame_end,
  output logic [FRAME_W-1:0] frame_count,
  output logic [13:0]        status
);

  logic [9:0] lines_m1, dots_m1, porch_q;
  logic [3:0] vs_lines;
  logic [6:0] hs_raw;
  logic       interlace;

  wire wr_size = wr_en && wr_sel == 2'd0;
  wire dot_last = dot_cnt == dots_m1;
  wire line_last = line_cnt == lines_m1;
  wire [9:0] line_inc = line_cnt + 10'd1;
  wire [9:0] new_last = wr_data[25:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_m1 <= 10'h270;
      dots_m1  <= 10'h35F;
      vs_lines <= 4'h5;
      hs_raw   <= 7'h3F;
      interlace <= 1'b0;
      porch_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: begin lines_m1 <= wr_data[25:16]; dots_m1 <= wr_data[9:0]; end
        2'd1: begin vs_lines <= wr_data[11:8]; hs_raw <= wr_data[6:0]; end
        2'd2: interlace <= wr_data[4];
        default: porch_q <= wr_data[9:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      dot_cnt <= '0;
      field_odd <= 1'b0;
      frame_end <= 1'b0;
      frame_count <= '0;
    end else begin
      frame_end <= 1'b0;
      if (wr_size) begin
        dot_cnt <= '0;
        line_cnt <= (line_cnt > new_last) ? new_last : line_cnt;
      end else if (dot_last) begin
        dot_cnt <= '0;
        if (line_last) begin
          line_cnt <= '0;
          if (interlace) field_odd <= ~field_odd;
        end else begin
          line_cnt <= line_inc;
          if (line_inc == FRAME_LINE) begin
            frame_end <= 1'b1;
            frame_count <= frame_count + 1'b1;
          end
        end
      end else begin
        dot_cnt <= dot_cnt + 10'd1;
      end
    end
  end

  wire [11:0] dot_w    = {2'b00, dot_cnt};
  wire [11:0] hs_width = ({5'd0, hs_raw} + 12'd1) << 1;
  wire [11:0] fp_len   = {2'b00, porch_q} + 12'd1;
  wire [11:0] line_len = {2'b00, dots_m1} + 12'd1;
  wire        same_par = line_cnt[0] == field_odd;
  wire        past_vs  = line_cnt >= {6'd0, vs_lines};

  logic act, hs_off, vs_off;
  always_comb begin
    act = 1'b0;
    hs_off = 1'b0;
    vs_off = 1'b0;
    if (same_par) begin
      hs_off = dot_w > hs_width;
      if (past_vs) begin
        vs_off = 1'b1;
        act = dot_w > fp_len;
      end
    end else if (past_vs) begin
      hs_off = 1'b1;
      vs_off = 1'b1;
      act = (dot_w + 12'(BACK_PORCH)) < line_len;
    end else begin
      hs_off = 1'b1;
    end
  end

  assign status = {vs_off, hs_off, act, field_odd, line_cnt};

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic [9:0]         line_cnt,
  input logic [9:0]         dot_cnt,
  input logic [9:0]         dots_m1,
  input logic               field_odd,
  input logic               frame_end,
  input logic [FRAME_W-1:0] frame_count,
  input logic [13:0]        status
);

  a_r4_frame_end_position: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (line_cnt == 10'h2A && dot_cnt == 10'd0));

  a_r4_frame_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> frame_count == $past(frame_count) + 1'b1);

  a_r5_position_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status[9:0] == line_cnt && status[10] == field_odd);

  a_r3_field_holds_midline: assert property (@(posedge clk) disable iff (!rst_n)
    dot_cnt != 10'd0 |-> $stable(field_odd));

  a_r2_dot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && wr_sel == 2'd0) |-> dot_cnt <= dots_m1);

  a_r10_size_write_zeroes_dot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> dot_cnt == 10'd0);

  a_r7_active_implies_vsync_off: assert property (@(posedge clk) disable iff (!rst_n)
    status[11] |-> status[13]);

endmodule

bind raster_timing raster_timing_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .line_cnt(line_cnt), .dot_cnt(dot_cnt), .dots_m1(dots_m1),
  .field_odd(field_odd), .frame_end(frame_end),
  .frame_count(frame_count), .status(status));

// File: tb/tb_raster_timing.sv
module tb_raster_timing;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [9:0] line_cnt, dot_cnt;
  logic field_odd, frame_end;
  logic [15:0] frame_count;
  logic [13:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  raster_timing #(.FRAME_W(16), .BACK_PORCH(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .line_cnt(line_cnt), .dot_cnt(dot_cnt), .field_odd(field_odd),
    .frame_end(frame_end), .frame_count(frame_count), .status(status));

  // {field, line, dot, expected status}; 50 lines x 20 dots, vsync 3, sync width 6, porch 5
  localparam logic [34:0] VEC [11] = '{
    {1'b0, 10'd2,  10'd3,  14'h0002},  // R7 before vsync, R6 below width
    {1'b0, 10'd2,  10'd7,  14'h1002},  // R6
    {1'b0, 10'd4,  10'd5,  14'h2004},  // R7 at porch
    {1'b0, 10'd4,  10'd6,  14'h2804},  // R7 past porch
    {1'b0, 10'd4,  10'd7,  14'h3804},  // R6 R7
    {1'b0, 10'd1,  10'd0,  14'h1001},  // R9
    {1'b0, 10'd5,  10'd15, 14'h3805},  // R8 before back porch
    {1'b0, 10'd5,  10'd16, 14'h3005},  // R8 in back porch
    {1'b1, 10'd5,  10'd2,  14'h2405},  // R5 R7 odd field
    {1'b1, 10'd6,  10'd0,  14'h3C06},  // R8 odd field
    {1'b1, 10'd49, 10'd19, 14'h3C31}   // R5 R6 R7 last dot
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // fsel 2 = any field; returns at the negedge where the position is shown
  task automatic wait_pos(input int fsel, input int ln, input int dt, output bit hit);
    hit = 1'b0;
    for (int i = 0; i < 4000 && !hit; i++) begin
      @(negedge clk);
      if (line_cnt == ln && dot_cnt == dt && (fsel == 2 || field_odd == fsel[0])) hit = 1'b1;
    end
    if (!hit) check(1'b0, "position not reached", ln, dt);
  endtask

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit hit;
    int cyc;
    logic [15:0] fc;
    logic f0;
    repeat (3) @(negedge clk);
    check(line_cnt == 0 && dot_cnt == 0 && !field_odd, "R1 counters", {line_cnt, dot_cnt}, 0);
    check(status == 0 && !frame_end && frame_count == 0, "R1 status", status, 0);
    rst_n = 1'b1;

    write_reg(2'd1, 32'h0000_0302);
    write_reg(2'd2, 32'h0000_0010);
    write_reg(2'd3, 32'h0000_0004);
    write_reg(2'd0, 32'h0031_0013);
    check(dot_cnt == 0 && line_cnt == 0, "R10 R11 size write", dot_cnt, 0);

    foreach (VEC[k]) begin
      wait_pos(int'(VEC[k][34]), int'(VEC[k][33:24]), int'(VEC[k][23:14]), hit);
      if (hit) check(status == VEC[k][13:0], $sformatf("R5-R9 vector %0d", k), status, VEC[k][13:0]);
    end

    // R2: dot wraps after the dots field, line advances
    wait_pos(2, 7, 19, hit);
    @(negedge clk);
    check(dot_cnt == 0 && line_cnt == 8, "R2 dot wrap", {line_cnt, dot_cnt}, {10'd8, 10'd0});

    // R3: frame wrap with interlace toggles field
    wait_pos(0, 49, 19, hit);
    @(negedge clk);
    check(line_cnt == 0 && dot_cnt == 0 && field_odd, "R3 interlaced wrap", {field_odd, line_cnt}, {1'b1, 10'd0});

    // R4: strobe position and spacing
    hit = 1'b0;
    for (int i = 0; i < 1200 && !hit; i++) begin @(negedge clk); hit = frame_end; end
    check(hit && line_cnt == 42 && dot_cnt == 0, "R4 strobe position", line_cnt, 42);
    fc = frame_count;
    cyc = 0; hit = 1'b0;
    for (int i = 0; i < 1200 && !hit; i++) begin @(negedge clk); cyc++; hit = frame_end; end
    check(cyc == 1000, "R4 strobe spacing", cyc, 1000);
    check(frame_count == fc + 16'd1, "R4 frame counter", frame_count, fc + 16'd1);

    // R10: clamp while deep in the frame
    wait_pos(2, 30, 5, hit);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0013_0013;
    @(negedge clk);
    wr_en = 1'b0;
    check(line_cnt == 19 && dot_cnt == 0, "R10 clamp", {line_cnt, dot_cnt}, {10'd19, 10'd0});
    f0 = field_odd;
    wait_pos(2, 19, 19, hit);
    @(negedge clk);
    check(line_cnt == 0 && field_odd == ~f0, "R3 wrap at new total", {field_odd, line_cnt}, {~f0, 10'd0});

    // R10: masked write keeps a small line count
    wait_pos(2, 3, 8, hit);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'hFC31_FC13;
    @(negedge clk);
    wr_en = 1'b0;
    check(line_cnt == 3 && dot_cnt == 0, "R10 masked keep", {line_cnt, dot_cnt}, {10'd3, 10'd0});
    wait_pos(2, 3, 19, hit);
    @(negedge clk);
    check(line_cnt == 4 && dot_cnt == 0, "R10 R2 masked dots", {line_cnt, dot_cnt}, {10'd4, 10'd0});

    // R3: progressive wrap leaves field alone
    write_reg(2'd2, 32'h0000_0000);
    f0 = field_odd;
    wait_pos(2, 49, 19, hit);
    @(negedge clk);
    check(line_cnt == 0 && field_odd == f0, "R3 progressive wrap", field_odd, f0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule